// File: doc/BRIEF.md
# Address Descriptor Decode Unit

This block holds a small bank of programmable address descriptors and decides, for every memory or I/O access presented to it, which downstream port claims the access. Descriptors of the offset kinds also produce a translated destination address. An access that no descriptor claims goes to a fixed subtractive default port, and its address passes through unchanged.

Seven descriptor kinds exist. Memory accesses can be claimed by an inclusive page range, a page range with an added page offset, a naturally aligned base/mask window, a base/mask window with an added page offset, or a 256 KB region in which each of sixteen 16 KB slices is either claimed or left to the subtractive port. I/O accesses can be claimed by a base/mask window or by an 8-byte region in which each byte is either claimed or left to the subtractive port. When several descriptors claim one access, the block flags the overlap and lets the lowest-numbered claimant win. A configuration port writes one whole descriptor per clock.

Top module: `adu_decode_unit`

## Requirements
- R1: While rst_n is low at a clock edge, every output register is cleared to zero and every descriptor is disabled, so after reset every access goes to the subtractive port.
- R2: The decode of an access presented with acc_valid high at a clock edge appears on the outputs after that same edge; res_valid is high after an edge exactly when acc_valid was high at it.
- R3: Kind code 0 (range) claims a memory access whose page number addr[31:12] lies between cfg_base and cfg_limit, both inclusive; the destination address equals the access address.
- R4: Kind code 1 (range with offset) claims like kind 0; the destination page is the access page plus cfg_offset modulo 2^20, with addr[11:0] kept.
- R5: Kind code 2 (base/mask) claims a memory access whose page number agrees with cfg_base in every bit set in cfg_limit; the destination address is unchanged.
- R6: Kind code 3 (base/mask with offset) claims like kind 2 and translates the page like kind 1.
- R7: Kind code 4 (sliced memory) covers the 256 KB region whose addr[31:18] equals cfg_base[19:6]; it claims the access only when cfg_slices bit addr[17:14] is set, otherwise the access is left to the subtractive port.
- R8: Kind code 5 (I/O base/mask) claims an I/O access whose addr[IO_W-1:0] agrees with cfg_base[IO_W-1:0] in every bit set in cfg_limit[IO_W-1:0]; kinds 0 to 4 never claim I/O accesses and kinds 5 and 6 never claim memory accesses.
- R9: Kind code 6 (sliced I/O) covers the 8 bytes whose addr[IO_W-1:3] equals cfg_base[IO_W-1:3]; it claims the access only when cfg_slices bit addr[2:0] is set.
- R10: An unclaimed access gives res_hit low, res_port equal to SUB_PORT and res_addr equal to the access address.
- R11: When two or more descriptors claim one access, res_overlap is high and port and destination come from the lowest-numbered claimant; with one claimant or none it is low.
- R12: A descriptor whose enable bit is clear, or whose kind code is 7, never claims an access.
- R13: A descriptor written at a clock edge applies to accesses presented at later edges; an access presented at the same edge is decoded with the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one descriptor this cycle |
| cfg_idx | input | IDX_W | Descriptor number to write |
| cfg_en | input | 1 | Enable bit of the written descriptor |
| cfg_kind | input | 3 | Kind code 0..7 |
| cfg_port | input | 3 | Destination port number |
| cfg_base | input | 20 | Start page, base page/address, or region base |
| cfg_limit | input | 20 | End page or mask |
| cfg_offset | input | 20 | Page offset for the offset kinds |
| cfg_slices | input | 16 | Per-slice claim bits for the sliced kinds |
| acc_valid | input | 1 | An access is presented |
| acc_io | input | 1 | High for an I/O access, low for memory |
| acc_addr | input | 32 | Access address |
| res_valid | output | 1 | A decode result is on the outputs |
| res_hit | output | 1 | A descriptor claimed the access |
| res_port | output | 3 | Port that takes the access |
| res_addr | output | 32 | Destination address |
| res_overlap | output | 1 | More than one descriptor claimed the access |

## Verification
Every decode result is due one clock edge after its access: the bench drives an access at a falling edge and compares all result ports at the next falling edge, after exactly one rising edge has registered the decode. A descriptor write shares that timing, so the bench presents an access on the very write edge and expects the old decode, then the new one on the following access. Sweeps over page numbers and I/O addresses cover the inside, edges and outside of each descriptor, against results computed arithmetically from the descriptor values the bench wrote.

// File: rtl/adu_pkg.sv
// Package: shared widths, kind codes and the descriptor record of the
// address descriptor decode unit. Assumes 32-bit byte addresses, 4 KB pages.
package adu_pkg;
    localparam int ADDR_W       = 32;
    localparam int PG_SHIFT     = 12;
    localparam int PAGE_W       = ADDR_W - PG_SHIFT;
    localparam int PORT_W       = 3;
    localparam int SLICE_N      = 16;
    localparam int MREG_SHIFT   = 18;   // 256 KB sliced region
    localparam int MSLICE_SHIFT = 14;   // 16 KB memory slice
    localparam int IOSL_SHIFT   = 3;    // 8-byte sliced I/O region

    typedef enum logic [2:0] {
        K_RANGE      = 3'd0,
        K_RANGE_OFS  = 3'd1,
        K_BMASK      = 3'd2,
        K_BMASK_OFS  = 3'd3,
        K_MSLICE     = 3'd4,
        K_IO_BMASK   = 3'd5,
        K_IO_SLICE   = 3'd6,
        K_NONE       = 3'd7
    } desc_kind_e;

    typedef struct packed {
        logic                en;
        desc_kind_e          kind;
        logic [PORT_W-1:0]   port;
        logic [PAGE_W-1:0]   base;
        logic [PAGE_W-1:0]   limit;
        logic [PAGE_W-1:0]   offset;
        logic [SLICE_N-1:0]  slices;
    } desc_t;
endpackage

// File: rtl/adu_desc_bank.sv
// Descriptor register bank: holds NUM_DESC descriptors, one whole
// descriptor written per clock. Assumes NUM_DESC >= 1.
module adu_desc_bank #(
    parameter int NUM_DESC = 4,
    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [IDX_W-1:0]                    wr_idx,
    input  adu_pkg::desc_t                      wr_desc,
    output adu_pkg::desc_t [NUM_DESC-1:0]       tbl_o
);
    adu_pkg::desc_t [NUM_DESC-1:0] tbl_q;

    // Clear all descriptors on reset, otherwise store the written one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (wr_en) begin
            tbl_q[wr_idx] <= wr_desc;
        end
    end

    assign tbl_o = tbl_q;
endmodule

// File: rtl/adu_desc_match.sv
// Single-descriptor matcher: decides whether one descriptor claims the
// access and forms its translated destination. Purely combinational.
// Assumes IO_W <= PAGE_W and IO_W > IOSL_SHIFT.
module adu_desc_match #(
    parameter int IO_W = 16
) (
    input  adu_pkg::desc_t                  desc_i,
    input  logic                            io_i,
    input  logic [adu_pkg::ADDR_W-1:0]      addr_i,
    output logic                            hit_o,
    output logic [adu_pkg::ADDR_W-1:0]      xlat_o
);
    import adu_pkg::*;

    localparam int RG_LO = MREG_SHIFT - PG_SHIFT;
    localparam int SL_LO = MSLICE_SHIFT - PG_SHIFT;

    logic [PAGE_W-1:0] pg;
    logic              in_range, in_bmask, in_mslice, in_iobm, in_ioslice;

    assign pg = addr_i[ADDR_W-1:PG_SHIFT];

    // Evaluate each geometric test once; the kind picks which one counts.
    always_comb begin
        in_range   = (pg >= desc_i.base) && (pg <= desc_i.limit);
        in_bmask   = ((pg ^ desc_i.base) & desc_i.limit) == '0;
        in_mslice  = (pg[PAGE_W-1:RG_LO] == desc_i.base[PAGE_W-1:RG_LO])
                     && desc_i.slices[pg[RG_LO-1:SL_LO]];
        in_iobm    = ((addr_i[IO_W-1:0] ^ desc_i.base[IO_W-1:0])
                      & desc_i.limit[IO_W-1:0]) == '0;
        in_ioslice = (addr_i[IO_W-1:IOSL_SHIFT] == desc_i.base[IO_W-1:IOSL_SHIFT])
                     && desc_i.slices[addr_i[IOSL_SHIFT-1:0]];
    end

    // Combine kind, access space and enable into the claim decision.
    always_comb begin
        hit_o = 1'b0;
        if (desc_i.en) begin
            unique case (desc_i.kind)
                K_RANGE, K_RANGE_OFS: hit_o = !io_i && in_range;
                K_BMASK, K_BMASK_OFS: hit_o = !io_i && in_bmask;
                K_MSLICE:             hit_o = !io_i && in_mslice;
                K_IO_BMASK:           hit_o =  io_i && in_iobm;
                K_IO_SLICE:           hit_o =  io_i && in_ioslice;
                default:              hit_o = 1'b0;
            endcase
        end
    end

    // Offset kinds add the page offset; all others pass the address through.
    always_comb begin
        if (desc_i.kind == K_RANGE_OFS || desc_i.kind == K_BMASK_OFS) begin
            xlat_o = {pg + desc_i.offset, addr_i[PG_SHIFT-1:0]};
        end else begin
            xlat_o = addr_i;
        end
    end
endmodule

// File: rtl/adu_pick.sv
// Priority picker: finds the lowest-numbered claimant and reports whether
// any or several descriptors claimed. Combinational.
module adu_pick #(
    parameter int N      = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      hits_i,
    output logic [IDX_W-1:0]  win_o,
    output logic              any_o,
    output logic              multi_o
);
    logic [CNT_W-1:0] cnt;

    // Scan from the top so the lowest index is written last and wins.
    always_comb begin
        win_o = '0;
        any_o = 1'b0;
        cnt   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits_i[i]) begin
                win_o = IDX_W'(i);
                any_o = 1'b1;
                cnt   = cnt + CNT_W'(1);
            end
        end
        multi_o = cnt > CNT_W'(1);
    end
endmodule

// File: rtl/adu_decode_unit.sv
// Top of the address descriptor decode unit: descriptor bank, one matcher
// per descriptor, lowest-index priority pick and the registered result.
// Assumes accesses and configuration writes share clk; result one edge later.
module adu_decode_unit #(
    parameter int NUM_DESC = 4,
    parameter int IO_W     = 16,
    parameter int SUB_PORT = 0,
    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic                         cfg_en,
    input  logic [2:0]                   cfg_kind,
    input  logic [2:0]                   cfg_port,
    input  logic [19:0]                  cfg_base,
    input  logic [19:0]                  cfg_limit,
    input  logic [19:0]                  cfg_offset,
    input  logic [15:0]                  cfg_slices,
    input  logic                         acc_valid,
    input  logic                         acc_io,
    input  logic [31:0]                  acc_addr,
    output logic                         res_valid,
    output logic                         res_hit,
    output logic [2:0]                   res_port,
    output logic [31:0]                  res_addr,
    output logic                         res_overlap
);
    import adu_pkg::*;

    desc_t                   wr_desc;
    desc_t [NUM_DESC-1:0]    tbl;
    logic  [NUM_DESC-1:0]    hits;
    logic  [ADDR_W-1:0]      xlat [NUM_DESC];
    logic  [IDX_W-1:0]       win;
    logic                    any_hit, multi_hit;

    // Assemble the descriptor record from the configuration pins.
    always_comb begin
        wr_desc.en     = cfg_en;
        wr_desc.kind   = desc_kind_e'(cfg_kind);
        wr_desc.port   = cfg_port;
        wr_desc.base   = cfg_base;
        wr_desc.limit  = cfg_limit;
        wr_desc.offset = cfg_offset;
        wr_desc.slices = cfg_slices;
    end

    adu_desc_bank #(.NUM_DESC(NUM_DESC)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_desc (wr_desc),
        .tbl_o   (tbl)
    );

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_match
        adu_desc_match #(.IO_W(IO_W)) match_i (
            .desc_i (tbl[g]),
            .io_i   (acc_io),
            .addr_i (acc_addr),
            .hit_o  (hits[g]),
            .xlat_o (xlat[g])
        );
    end

    adu_pick #(.N(NUM_DESC)) pick_i (
        .hits_i  (hits),
        .win_o   (win),
        .any_o   (any_hit),
        .multi_o (multi_hit)
    );

    // Register the decode of the access presented at this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_hit     <= 1'b0;
            res_port    <= '0;
            res_addr    <= '0;
            res_overlap <= 1'b0;
        end else begin
            res_valid   <= acc_valid;
            res_hit     <= any_hit;
            res_overlap <= multi_hit;
            res_port    <= any_hit ? tbl[win].port : PORT_W'(SUB_PORT);
            res_addr    <= any_hit ? xlat[win] : acc_addr;
        end
    end
endmodule

// File: rtl/adu_decode_chk.sv
// Checker for adu_decode_unit: timing and fall-through properties over the
// ports. Attached with the bind below.
module adu_decode_chk #(
    parameter int SUB_PORT = 0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic [31:0] acc_addr,
    input logic        res_valid,
    input logic        res_hit,
    input logic [2:0]  res_port,
    input logic [31:0] res_addr,
    input logic        res_overlap
);
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    a_r11_overlap_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        res_overlap |-> res_hit);

    a_r10_miss_port: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_port == 3'(SUB_PORT)));

    a_r10_miss_addr: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (res_hit || res_addr == $past(acc_addr)));
endmodule

bind adu_decode_unit adu_decode_chk #(.SUB_PORT(SUB_PORT)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_port    (res_port),
    .res_addr    (res_addr),
    .res_overlap (res_overlap)
);

// File: tb/adu_decode_unit_tb_top.sv
// Bench for adu_decode_unit: sweeps addresses over several descriptor
// configurations and compares against an arithmetic model of the rules.
module adu_decode_unit_tb_top;
    localparam int ND  = 4;
    localparam int SUB = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [2:0]  cfg_kind = '0;
    logic [2:0]  cfg_port = '0;
    logic [19:0] cfg_base = '0, cfg_limit = '0, cfg_offset = '0;
    logic [15:0] cfg_slices = '0;
    logic        acc_valid = 1'b0, acc_io = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        res_valid, res_hit, res_overlap;
    logic [2:0]  res_port;
    logic [31:0] res_addr;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    // Bench-side copy of what was written.
    bit          m_en   [ND];
    int          m_kind [ND];
    logic [2:0]  m_port [ND];
    logic [19:0] m_base [ND], m_lim [ND], m_off [ND];
    logic [15:0] m_sl   [ND];

    always #4 clk = ~clk;   // 125 MHz

    adu_decode_unit #(.NUM_DESC(ND), .IO_W(16), .SUB_PORT(SUB)) dut_i (.*);

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic set_model(int i, bit en, int k, logic [2:0] p, logic [19:0] b,
                             logic [19:0] l, logic [19:0] o, logic [15:0] s);
        m_en[i] = en; m_kind[i] = k; m_port[i] = p;
        m_base[i] = b; m_lim[i] = l; m_off[i] = o; m_sl[i] = s;
    endtask

    task automatic drive_cfg(int i, bit en, int k, logic [2:0] p, logic [19:0] b,
                             logic [19:0] l, logic [19:0] o, logic [15:0] s);
        cfg_we = 1'b1; cfg_idx = 2'(i); cfg_en = en; cfg_kind = 3'(k);
        cfg_port = p; cfg_base = b; cfg_limit = l; cfg_offset = o; cfg_slices = s;
    endtask

    task automatic wr(int i, bit en, int k, logic [2:0] p, logic [19:0] b,
                      logic [19:0] l, logic [19:0] o, logic [15:0] s);
        @(negedge clk);
        drive_cfg(i, en, k, p, b, l, o, s);
        @(negedge clk);
        cfg_we = 1'b0;
        set_model(i, en, k, p, b, l, o, s);
    endtask

    // Arithmetic model of the claim rules R3..R12.
    task automatic model(bit io, logic [31:0] a, output bit hit, output bit ovl,
                         output logic [2:0] port, output logic [31:0] dst, output int wk);
        int n = 0;
        logic [19:0] pg = a[31:12];
        logic [15:0] ia = a[15:0];
        hit = 0; ovl = 0; port = 3'(SUB); dst = a; wk = -1;
        for (int i = 0; i < ND; i++) begin
            bit m = 0;
            if (m_en[i]) begin
                case (m_kind[i])
                    0, 1: m = !io && pg >= m_base[i] && pg <= m_lim[i];
                    2, 3: m = !io && ((pg & m_lim[i]) == (m_base[i] & m_lim[i]));
                    4:    m = !io && (pg / 64 == m_base[i] / 64) && m_sl[i][(pg / 4) % 16];
                    5:    m = io && ((ia & m_lim[i][15:0]) == (m_base[i][15:0] & m_lim[i][15:0]));
                    6:    m = io && (ia / 8 == m_base[i][15:0] / 8) && m_sl[i][ia % 8];
                    default: m = 0;
                endcase
            end
            if (m) begin
                n++;
                if (!hit) begin
                    hit = 1; port = m_port[i]; wk = m_kind[i];
                    if (wk == 1 || wk == 3)
                        dst = (32'(20'(pg + m_off[i])) << 12) | (a & 32'hFFF);
                end
            end
        end
        ovl = n > 1;
    endtask

    function automatic string tag_of(int wk, bit ovl);
        string t;
        case (wk)
            0: t = "R3"; 1: t = "R4"; 2: t = "R5"; 3: t = "R6";
            4: t = "R7"; 5: t = "R8"; 6: t = "R9"; default: t = "R10";
        endcase
        return ovl ? {"R11/", t} : t;
    endfunction

    task automatic compare(string tag, bit e_hit, bit e_ovl, logic [2:0] e_port, logic [31:0] e_dst);
        checks++;
        if (res_valid !== 1'b1 || res_hit !== e_hit || res_overlap !== e_ovl ||
            res_port !== e_port || res_addr !== e_dst) begin
            fails++;
            $display("FAIL %s: actual v=%b hit=%b ovl=%b port=%0d addr=%h expected v=1 hit=%b ovl=%b port=%0d addr=%h",
                     tag, res_valid, res_hit, res_overlap, res_port, res_addr,
                     e_hit, e_ovl, e_port, e_dst);
        end
    endtask

    // Present one access, sample one rising edge later, compare to model.
    task automatic acc(bit io, logic [31:0] a, string note);
        bit h, o; logic [2:0] p; logic [31:0] d; int wk;
        @(negedge clk);
        acc_valid = 1'b1; acc_io = io; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        model(io, a, h, o, p, d, wk);
        compare({note, tag_of(wk, o)}, h, o, p, d);
    endtask

    initial begin
        for (int i = 0; i < ND; i++) set_model(i, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of all outputs.
        checks++;
        if (res_valid !== 0 || res_hit !== 0 || res_overlap !== 0 || res_port !== 0 || res_addr !== 0) begin
            fails++;
            $display("FAIL R1: actual v=%b hit=%b ovl=%b port=%0d addr=%h expected all zero",
                     res_valid, res_hit, res_overlap, res_port, res_addr);
        end
        // R1/R10: empty bank sends everything subtractive.
        for (int p = 0; p < 64; p++) acc(0, (32'(p) << 12) | 32'(p * 3), "R1 ");

        // R2: no access gives res_valid low after the edge.
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: actual res_valid=%b expected 0", res_valid);
        end

        // Scenario: the four page-based memory kinds, with wrap of the offset.
        wr(0, 1, 0, 3'd1, 20'h00010, 20'h0001F, 20'h0, 16'h0);
        wr(1, 1, 1, 3'd2, 20'h00030, 20'h0003F, 20'hFFFD0, 16'h0);
        wr(2, 1, 2, 3'd3, 20'h00040, 20'hFFFE0, 20'h0, 16'h0);
        wr(3, 1, 3, 3'd4, 20'h00080, 20'hFFFC0, 20'h00100, 16'h0);
        for (int p = 0; p < 256; p++) acc(0, (32'(p) << 12) | 32'((p * 37) & 12'hFFF), "");
        // R8: the same addresses as I/O are claimed by none of the memory kinds.
        for (int p = 0; p < 256; p++) acc(1, (32'(p) << 12) | 32'(p), "R8 ");

        // Scenario: sliced memory, I/O kinds, disabled descriptor (R12).
        wr(0, 1, 4, 3'd5, 20'h00100, 20'h0, 20'h0, 16'hA5C3);
        wr(1, 1, 5, 3'd6, 20'h00300, 20'h0FFF0, 20'h0, 16'h0);
        wr(2, 1, 6, 3'd7, 20'h00060, 20'h0, 20'h0, 16'h005A);
        wr(3, 0, 0, 3'd3, 20'h00100, 20'h0013F, 20'h0, 16'h0);
        for (int p = 16'h0F0; p < 16'h150; p++) acc(0, (32'(p) << 12) | 32'h0A4, "R12 ");
        for (int a = 16'h2F0; a < 16'h320; a++) acc(1, 32'(a), "");
        for (int a = 16'h058; a < 16'h070; a++) acc(1, 32'(a), "");
        // R8: memory access at I/O-matching addresses is not claimed by I/O kinds.
        for (int a = 16'h300; a < 16'h308; a++) acc(0, 32'(a), "R8 ");

        // Scenario: overlap priority and the never-matching kind 7.
        wr(0, 1, 7, 3'd6, 20'h00000, 20'hFFFFF, 20'h0, 16'hFFFF);
        wr(1, 1, 0, 3'd1, 20'h00010, 20'h00020, 20'h0, 16'h0);
        wr(2, 1, 2, 3'd2, 20'h00018, 20'hFFFF8, 20'h0, 16'h0);
        wr(3, 1, 1, 3'd3, 20'h0001C, 20'h0002F, 20'h00400, 16'h0);
        for (int p = 0; p < 48; p++) acc(0, (32'(p) << 12) | 32'h777, "R11 R12 ");

        // R13: an access on the write edge uses the old contents.
        wr(0, 0, 0, 3'd0, 20'h0, 20'h0, 20'h0, 16'h0);
        wr(1, 0, 0, 3'd0, 20'h0, 20'h0, 20'h0, 16'h0);
        wr(2, 0, 0, 3'd0, 20'h0, 20'h0, 20'h0, 16'h0);
        wr(3, 0, 0, 3'd0, 20'h0, 20'h0, 20'h0, 16'h0);
        @(negedge clk);
        drive_cfg(0, 1, 0, 3'd5, 20'h00200, 20'h00200, 20'h0, 16'h0);
        acc_valid = 1'b1; acc_io = 1'b0; acc_addr = 32'h0020_0123;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        compare("R13 same-edge", 1'b0, 1'b0, 3'(SUB), 32'h0020_0123);
        set_model(0, 1, 0, 3'd5, 20'h00200, 20'h00200, 20'h0, 16'h0);
        acc(0, 32'h0020_0123, "R13 ");
        acc(0, 32'h0020_1123, "R13 ");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule